// File: doc/BRIEF.md
# Line-to-message interrupt redirector

This block turns a small group of wired interrupt inputs into memory-write messages aimed at the processor side. Every input line has its own table entry. The entry holds an enable, a trigger mode (edge or level), an input polarity, a lowest-priority delivery flag, an 8-bit vector and a 16-bit destination. When an enabled line becomes active, the block raises a single write request. The request address comes from the line's destination and the request data from its vector and delivery flag. The request stays up until the receiver accepts it.

Software reaches the table indirectly over a simple 32-bit register bus. It first writes an internal index to a select register. It then reads or writes that internal register through a data window. A level-triggered line sends one message and then stays blocked until software writes the line's vector to the end-of-interrupt register. If the line is still active at that point, it sends again. When more than one line is waiting, the lowest-numbered line goes first.

Top module: `irq_redir`

## Requirements
- R1: After reset every entry reads as zero (all lines disabled), the select register reads zero and `msgValid` is low.
- R2: Bus offset 0x00 is the select register (bits 7:0, readable). Offset 0x10 is the window onto the selected internal register. Offset 0x40 is the write-only end-of-interrupt register. Reads of any other offset, including 0x40, return zero.
- R3: Internal index 0x01 is read-only and reads `{8'h00, NUM_LINES-1, 8'h00, VERSION}`, with the top entry number in bits 23:16 and the version in bits 7:0 (0x00060021 by default). Writes to it have no effect.
- R4: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. In the low word, bits 7:0 are the vector, bit 8 is lowest-priority delivery, bit 13 is active-low polarity, bit 15 selects level trigger (clear means edge) and bit 16 is the enable. In the high word, bits 31:16 are the destination. All other bits read zero.
- R5: Reads of unimplemented internal indices (for example 0x05, or an entry number of NUM_LINES or above) return zero, and writes to them change nothing.
- R6: A message carries `msgAddr = {destination, 16'h0000}` and `msgData = {23'b0, lowest-priority bit, vector}`.
- R7: An enabled edge line sends exactly one message for each rising edge of its polarity-corrected input, however long the input stays high.
- R8: An enabled level line sends one message and no more until an end-of-interrupt write whose bits 7:0 equal its vector. It then sends again if it is still active. An end-of-interrupt write with a different vector, or one made after the line has gone inactive, sends nothing.
- R9: Enabling a line whose polarity-corrected input is already active sends one message.
- R10: An active-low line is active while its input pin is low and inactive while the pin is high.
- R11: When several lines are waiting at once, messages go out in ascending line order.
- R12: While `msgValid` is high and `msgReady` is low, `msgValid`, `msgAddr` and `msgData` hold steady. Each accepted handshake is one message.
- R13: A disabled line sends no message, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register bus write strobe |
| regAddr | input | 8 | Register bus byte offset |
| regWdata | input | 32 | Register bus write data |
| regRdata | output | 32 | Register bus read data for `regAddr` (combinational) |
| irqIn | input | NUM_LINES | Interrupt input pins |
| msgValid | output | 1 | Write message request |
| msgReady | input | 1 | Receiver accepts the message |
| msgAddr | output | 32 | Message write address |
| msgData | output | 32 | Message write data |

## Verification
Five patterns exercise the main function:
- An edge line held high for many cycles and then pulsed again separates edge-counting from level-following.
- A level line held active across a mismatched and then a matching end-of-interrupt write shows that re-arming depends on the vector.
- Raising an input while its line is disabled, and enabling it afterwards, separates the enable mask from enable-time sampling.
- An active-low line driven from high to low and back checks that polarity is applied before edge detection.
- Two lines raised together while the receiver stalls check both the ascending order and that address and data hold steady during back-pressure.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int LINE_W = 3;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;

  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int BIT_EN   = 16;
  localparam int BIT_LVL  = 15;
  localparam int BIT_ALOW = 13;
  localparam int BIT_LPRI = 8;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              winTbl;
    logic              winHi;
    logic              winVer;
    logic [LINE_W-1:0] winLine;
    logic              load;
    logic [LINE_W-1:0] loadLine;
  } dpStrobe_t;
endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWr,
  input  logic [7:0]                  regAddr,
  input  logic [7:0]                  wrByte,
  input  logic [NUM_LINES-1:0]        irqIn,
  input  logic [NUM_LINES-1:0]        cfgEn,
  input  logic [NUM_LINES-1:0]        cfgLevel,
  input  logic [NUM_LINES-1:0]        cfgActLow,
  input  logic [NUM_LINES-1:0][7:0]   cfgVec,
  input  logic                        msgReady,
  output logic [7:0]                  selIdx,
  output dpStrobe_t                   strobe,
  output logic                        msgValid
);
  localparam logic [7:0] NUM_L8 = 8'(NUM_LINES);
  localparam logic [NUM_LINES-1:0] ONE_N = NUM_LINES'(1);

  logic [7:0]           tblOfs;
  logic                 eoiWr;
  logic [NUM_LINES-1:0] lvlNow, prevLvl, prevEn, rise, enRise;
  logic [NUM_LINES-1:0] pend, inSvc, req, eoiHit;
  logic                 busy, accept, launch;
  logic [LINE_W-1:0]    curLine, pick;

  // select register
  always_ff @(posedge clk) begin
    if (!rstN) selIdx <= '0;
    else if (regWr && regAddr == OFS_SEL) selIdx <= wrByte;
  end

  // window decode
  always_comb begin
    tblOfs          = selIdx - IDX_TBL;
    strobe.winVer   = (selIdx == IDX_VER);
    strobe.winTbl   = (selIdx >= IDX_TBL) && ({1'b0, tblOfs[7:1]} < NUM_L8);
    strobe.winHi    = tblOfs[0];
    strobe.winLine  = tblOfs[LINE_W:1];
    strobe.wrLo     = regWr && regAddr == OFS_WIN && strobe.winTbl && !tblOfs[0];
    strobe.wrHi     = regWr && regAddr == OFS_WIN && strobe.winTbl && tblOfs[0];
    strobe.load     = launch;
    strobe.loadLine = pick;
  end

  assign eoiWr  = regWr && regAddr == OFS_EOI;
  assign lvlNow = irqIn ^ cfgActLow;
  assign rise   = lvlNow & ~prevLvl;
  assign enRise = cfgEn & ~prevEn;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      eoiHit[i] = eoiWr && cfgLevel[i] && cfgVec[i] == wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl <= '0;
      prevEn  <= '0;
    end else begin
      prevLvl <= lvlNow;
      prevEn  <= cfgEn;
    end
  end

  assign accept = busy && msgReady;

  // pending (edge) and in-service (level) tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend  <= '0;
      inSvc <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (!cfgEn[i] || cfgLevel[i]) begin
          pend[i] <= 1'b0;
        end else begin
          if (accept && curLine == LINE_W'(i)) pend[i] <= 1'b0;
          if (rise[i] || (enRise[i] && lvlNow[i])) pend[i] <= 1'b1;
        end
        if (!cfgEn[i] || !cfgLevel[i]) begin
          inSvc[i] <= 1'b0;
        end else begin
          if (accept && curLine == LINE_W'(i)) inSvc[i] <= 1'b1;
          if (eoiHit[i]) inSvc[i] <= 1'b0;
        end
      end
    end
  end

  assign req = cfgEn & ((cfgLevel & lvlNow & ~inSvc) | (~cfgLevel & pend));

  // lowest line number wins
  always_comb begin
    pick = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (req[i]) pick = LINE_W'(i);
  end

  assign launch = !busy && (|req);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curLine <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      curLine <= pick;
    end else if (accept) begin
      busy    <= 1'b0;
    end
  end

  assign msgValid = busy;

  // R11
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> ((req & ((ONE_N << pick) - ONE_N)) == '0));

  // R13
  launch_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> cfgEn[pick]);

  // R8
  level_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cfgEn[curLine] && cfgLevel[curLine] && !eoiWr)
      |=> inSvc[$past(curLine)]);
endmodule

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
#(
  parameter int          NUM_LINES = 7,
  parameter logic [7:0]  VERSION   = 8'h21
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [31:0]                 regWdata,
  input  logic [7:0]                  regAddr,
  input  logic [7:0]                  selIdx,
  output logic [31:0]                 regRdata,
  output logic [NUM_LINES-1:0]        cfgEn,
  output logic [NUM_LINES-1:0]        cfgLevel,
  output logic [NUM_LINES-1:0]        cfgActLow,
  output logic [NUM_LINES-1:0][7:0]   cfgVec,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData
);
  localparam logic [7:0] TOP_ENTRY = 8'(NUM_LINES - 1);

  logic [NUM_LINES-1:0]       lpri;
  logic [NUM_LINES-1:0][15:0] dest;
  logic [31:0]                loWord, hiWord, winData;
  logic                       unusedWd;

  assign unusedWd = ^{regWdata[14], regWdata[12:9]};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgVec[g]    <= '0;
        lpri[g]      <= 1'b0;
        cfgActLow[g] <= 1'b0;
        cfgLevel[g]  <= 1'b0;
        cfgEn[g]     <= 1'b0;
        dest[g]      <= '0;
      end else begin
        if (strobe.wrLo && strobe.winLine == LINE_W'(g)) begin
          cfgVec[g]    <= regWdata[7:0];
          lpri[g]      <= regWdata[BIT_LPRI];
          cfgActLow[g] <= regWdata[BIT_ALOW];
          cfgLevel[g]  <= regWdata[BIT_LVL];
          cfgEn[g]     <= regWdata[BIT_EN];
        end
        if (strobe.wrHi && strobe.winLine == LINE_W'(g))
          dest[g] <= regWdata[31:16];
      end
    end
  end

  always_comb begin
    loWord = '0;
    loWord[7:0]      = cfgVec[strobe.winLine];
    loWord[BIT_LPRI] = lpri[strobe.winLine];
    loWord[BIT_ALOW] = cfgActLow[strobe.winLine];
    loWord[BIT_LVL]  = cfgLevel[strobe.winLine];
    loWord[BIT_EN]   = cfgEn[strobe.winLine];
    hiWord = {dest[strobe.winLine], 16'h0000};
    if (strobe.winVer)      winData = {8'h00, TOP_ENTRY, 8'h00, VERSION};
    else if (strobe.winTbl) winData = strobe.winHi ? hiWord : loWord;
    else                    winData = '0;
    case (regAddr)
      OFS_SEL: regRdata = {24'h0, selIdx};
      OFS_WIN: regRdata = winData;
      default: regRdata = '0;
    endcase
  end

  // message registers, captured once at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobe.load) begin
      msgAddr <= {dest[strobe.loadLine], 16'h0000};
      msgData <= {23'h0, lpri[strobe.loadLine], cfgVec[strobe.loadLine]};
    end
  end
endmodule

// File: rtl/irq_redir.sv
module irq_redir
  import irq_redir_pkg::*;
#(
  parameter int         NUM_LINES = 7,
  parameter logic [7:0] VERSION   = 8'h21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [7:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [31:0]          msgAddr,
  output logic [31:0]          msgData
);
  dpStrobe_t                  strobe;
  logic [7:0]                 selIdx;
  logic [NUM_LINES-1:0]       cfgEn, cfgLevel, cfgActLow;
  logic [NUM_LINES-1:0][7:0]  cfgVec;

  initial begin
    lines_range_chk: assert (NUM_LINES >= 1 && NUM_LINES <= 7);
  end

  irq_redir_ctrl #(.NUM_LINES(NUM_LINES)) i_ctrl (
    .clk, .rstN, .regWr, .regAddr,
    .wrByte   (regWdata[7:0]),
    .irqIn, .cfgEn, .cfgLevel, .cfgActLow, .cfgVec,
    .msgReady, .selIdx, .strobe, .msgValid
  );

  irq_redir_dp #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) i_dp (
    .clk, .rstN, .strobe, .regWdata, .regAddr, .selIdx, .regRdata,
    .cfgEn, .cfgLevel, .cfgActLow, .cfgVec, .msgAddr, .msgData
  );

  // R12
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));
endmodule

// File: tb/test_irq_redir.sv
module test_irq_redir;
  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [N-1:0] irqIn = '0;
  logic        msgValid, msgReady;
  logic [31:0] msgAddr, msgData;
  logic        readyDrv = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [63:0] expQ[$];

  assign msgReady = readyDrv;
  always #4 clk = ~clk;

  irq_redir i_irq_redir (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata, .irqIn,
    .msgValid, .msgReady, .msgAddr, .msgData
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic idxWrite(input logic [7:0] idx, input logic [31:0] d);
    regWrite(8'h00, {24'h0, idx});
    regWrite(8'h10, d);
  endtask

  task automatic idxRead(input logic [7:0] idx, output logic [31:0] d);
    regWrite(8'h00, {24'h0, idx});
    regRead(8'h10, d);
  endtask

  task automatic pushExp(input logic [15:0] dst, input logic lp, input logic [7:0] vec);
    expQ.push_back({dst, 16'h0000, 23'h0, lp, vec});
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  logic        holding = 1'b0;
  logic [31:0] heldAddr, heldData;
  always @(negedge clk) begin
    if (rstN) begin
      if (msgValid) begin
        if (holding) begin
          checkEq("R12 addr held", msgAddr, heldAddr);
          checkEq("R12 data held", msgData, heldData);
        end
        if (msgReady) begin
          if (expQ.size() == 0) begin
            checks++; fails++;
            $display("FAIL R13/R7/R8 unexpected message: got %h/%h expected none", msgAddr, msgData);
          end else begin
            logic [63:0] e;
            e = expQ.pop_front();
            checkEq("R6 message addr", msgAddr, e[63:32]);
            checkEq("R6 message data", msgData, e[31:0]);
          end
        end
        holding  = !msgReady;
        heldAddr = msgAddr;
        heldData = msgData;
      end else begin
        if (holding) begin
          checks++; fails++;
          $display("FAIL R12 valid dropped: got 0 expected 1");
        end
        holding = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    checkEq("R1 valid low", {31'h0, msgValid}, 32'h0);
    regRead(8'h00, rd);       checkEq("R1 select zero", rd, 32'h0);
    idxRead(8'h10, rd);       checkEq("R1 entry0 low", rd, 32'h0);
    idxRead(8'h1C, rd);       checkEq("R1 entry6 low", rd, 32'h0);

    // R2 register map
    regWrite(8'h00, 32'h0000_0013);
    regRead(8'h00, rd);       checkEq("R2 select readback", rd, 32'h13);
    regRead(8'h20, rd);       checkEq("R2 other offset", rd, 32'h0);
    regRead(8'h40, rd);       checkEq("R2 eoi reads zero", rd, 32'h0);

    // R3 version
    idxRead(8'h01, rd);       checkEq("R3 version", rd, 32'h0006_0021);
    idxWrite(8'h01, 32'hFFFF_FFFF);
    idxRead(8'h01, rd);       checkEq("R3 version read-only", rd, 32'h0006_0021);

    // R4 field layout (enable kept clear)
    idxWrite(8'h1C, 32'hFFFE_FFFF);
    idxRead(8'h1C, rd);       checkEq("R4 low word mask", rd, 32'h0000_A1FF);
    idxWrite(8'h1D, 32'hFFFF_FFFF);
    idxRead(8'h1D, rd);       checkEq("R4 high word mask", rd, 32'hFFFF_0000);
    idxWrite(8'h1C, 32'h0);

    // R5 unimplemented indices
    idxWrite(8'h1E, 32'h0001_80FF);
    idxRead(8'h1E, rd);       checkEq("R5 entry7 reads zero", rd, 32'h0);
    idxRead(8'h05, rd);       checkEq("R5 index05 reads zero", rd, 32'h0);
    idxRead(8'h1A, rd);       checkEq("R5 entry5 untouched", rd, 32'h0);
    waitCyc(10);
    checkEq("R5 no message", expQ.size(), 0);

    // R7 edge line 0: one message per rising edge
    idxWrite(8'h11, 32'h1000_0000);
    idxWrite(8'h10, 32'h0001_0010);
    pushExp(16'h1000, 1'b0, 8'h10);
    irqIn[0] = 1'b1;
    waitCyc(20);
    checkEq("R7 one message while held", expQ.size(), 0);
    irqIn[0] = 1'b0;
    waitCyc(3);
    pushExp(16'h1000, 1'b0, 8'h10);
    irqIn[0] = 1'b1;
    waitCyc(10);
    checkEq("R7 second edge sent", expQ.size(), 0);
    irqIn[0] = 1'b0;

    // R13 / R9: line 1 disabled then enabled while high
    idxWrite(8'h13, 32'h0101_0000);
    idxWrite(8'h12, 32'h0000_0011);
    irqIn[1] = 1'b1;
    waitCyc(10);
    checkEq("R13 disabled silent", expQ.size(), 0);
    pushExp(16'h0101, 1'b0, 8'h11);
    idxWrite(8'h12, 32'h0001_0011);
    waitCyc(10);
    checkEq("R9 enable while active", expQ.size(), 0);
    irqIn[1] = 1'b0;

    // R10 active-low edge line 4
    irqIn[4] = 1'b1;
    idxWrite(8'h19, 32'h4000_0000);
    idxWrite(8'h18, 32'h0001_2044);
    waitCyc(10);
    checkEq("R10 high pin inactive", expQ.size(), 0);
    pushExp(16'h4000, 1'b0, 8'h44);
    irqIn[4] = 1'b0;
    waitCyc(10);
    checkEq("R10 low pin active", expQ.size(), 0);
    irqIn[4] = 1'b1;
    waitCyc(10);
    checkEq("R10 release silent", expQ.size(), 0);

    // R8 level line 3 with end-of-interrupt
    idxWrite(8'h17, 32'hABCD_0000);
    idxWrite(8'h16, 32'h0001_8033);
    pushExp(16'hABCD, 1'b0, 8'h33);
    irqIn[3] = 1'b1;
    waitCyc(20);
    checkEq("R8 single until eoi", expQ.size(), 0);
    regWrite(8'h40, 32'h0000_0044);
    waitCyc(10);
    checkEq("R8 wrong vector silent", expQ.size(), 0);
    pushExp(16'hABCD, 1'b0, 8'h33);
    regWrite(8'h40, 32'h0000_0033);
    waitCyc(10);
    checkEq("R8 eoi re-arms", expQ.size(), 0);
    irqIn[3] = 1'b0;
    waitCyc(2);
    regWrite(8'h40, 32'h0000_0033);
    waitCyc(10);
    checkEq("R8 inactive after eoi silent", expQ.size(), 0);

    // R11 / R12: lines 2 and 5 together under back-pressure
    idxWrite(8'h15, 32'h0202_0000);
    idxWrite(8'h14, 32'h0001_0122);
    idxWrite(8'h1B, 32'h0505_0000);
    idxWrite(8'h1A, 32'h0001_0055);
    @(posedge clk); #1;
    readyDrv = 1'b0;
    pushExp(16'h0202, 1'b1, 8'h22);
    pushExp(16'h0505, 1'b0, 8'h55);
    irqIn[5] = 1'b1;
    irqIn[2] = 1'b1;
    waitCyc(8);
    checkEq("R12 valid under stall", {31'h0, msgValid}, 32'h1);
    checkEq("R11 nothing sent yet", expQ.size(), 2);
    readyDrv = 1'b1;
    waitCyc(10);
    checkEq("R11 both sent in order", expQ.size(), 0);
    checkEq("R12 idle after", {31'h0, msgValid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule